// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register file of a colour LCD controller. It decodes a 4 KB window on a simple word bus: a request strobe, a write enable, a byte address, write data and registered read data. The window holds four panel timing words, upper and lower frame base addresses, a control word, an interrupt mask, raw and masked interrupt status, and a write-only clear register. It also holds a block of read-only identification bytes and a 128-word palette store. The palette store has a second, combinational read port for the pixel path.

From the stored words the block continuously drives the panel geometry, the colour mode and the ordering controls, and an enable that needs two separate control bits. Interrupt sources lie outside the block. They arrive as one-cycle event pulses that set raw status bits. Software masks those bits and clears them, and a single interrupt line summarises the result.

A `VARIANT` parameter selects the register layout and the identification code. Variant 0 is the base layout. Variants 1 and 2 exchange the mask and control addresses. Variant 2 also reports a different identification code.

Top module: `lcdc_regif`

## Requirements
- R1: Timing words 0–3 (word indices 0–3) and the upper and lower base words (indices 4 and 5) read back the last full 32-bit value written to them. The current-upper (index 11) and current-lower (index 12) registers read the same values as the upper and lower base words.
- R2: `cols_o` equals ((t0 AND 0xFC) + 4) × 4, where t0 is the last value written to timing word 0. It reads 16 out of reset.
- R3: `rows_o` equals (t1 AND 0x3FF) + 1, where t1 is the last value written to timing word 1. It reads 1 out of reset.
- R4: The control word holds write-data bits 15:0. `bpp_o` is control bits 3:1, `bgr_o` is bit 8, `be_byte_o` is bit 9 and `be_pix_o` is bit 10. `en_o` is high only when bit 0 and bit 11 are both set.
- R5: With `VARIANT` 0, index 6 is the interrupt mask (bits 3:0) and index 7 is the control word. With any other variant the two swap for both reads and writes.
- R6: An event pulse sets the matching raw status bits, which read at index 8. A write to index 10 clears each raw bit whose write-data bit is 1. If an event and a clear hit the same bit in the same cycle, the event wins.
- R7: Index 9 reads raw status AND mask. `irq_o` is high exactly when that value is non-zero.
- R8: Indices 1016–1023 (offsets 0xFE0–0xFFC) each read one identification byte in bits 7:0. Variants 0 and 1 return 10 11 04 00 0D F0 05 B1, and variant 2 returns 11 11 24 00 0D F0 05 B1, in order of rising address.
- R9: Indices 128–255 (offsets 0x200–0x3FC) map to palette words 0–127. Each word reads back the full word last written. `pal_rdata_o` shows palette word `pal_raddr_i` combinationally.
- R10: Any index outside the mapped sets above reads zero and ignores writes. An access to such an index raises `err_o` for exactly the one cycle after the access edge.
- R11: After reset every register, the raw status, `rdata_o`, `err_o` and `irq_o` are zero.
- R12: Writes to indices 8, 9, 11, 12 and to the identification bytes change no state and raise no error.
- R13: `rdata_o` is updated at the edge that samples a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 12 | Byte address in the window; bits 1:0 ignored |
| wdata_i | input | DATA_W | Write data |
| evt_i | input | NUM_IRQ | Interrupt event pulses, set raw status |
| pal_raddr_i | input | 7 | Pixel-side palette read index |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse after an unmapped access |
| irq_o | output | 1 | Masked interrupt summary |
| cols_o | output | COL_W | Panel width in pixels |
| rows_o | output | ROW_W | Panel height in lines |
| bpp_o | output | 3 | Bits-per-pixel code |
| en_o | output | 1 | Display enabled (enable and power both set) |
| bgr_o | output | 1 | Blue/red swap select |
| be_byte_o | output | 1 | Big-endian byte order select |
| be_pix_o | output | 1 | Big-endian pixel order select |
| pal_rdata_o | output | DATA_W | Pixel-side palette word |

## Verification
The bench builds three copies of the block with the default 32-bit data and four interrupt bits, one for each `VARIANT` value, and drives the same bus traffic into all three. Shared traffic makes the address swap and the two identification codes directly comparable. Four interrupt bits make the full 16 × 16 grid of event and clear patterns cheap to cover. The small 10-bit word index lets the bench sweep every address for reads and every unmapped or read-only address for writes. Every value written into timing words 0 and 1 reaches the geometry outputs.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int unsigned IDX_W     = 10;
  localparam int unsigned PAL_DEPTH = 128;
  localparam int unsigned PAL_AW    = $clog2(PAL_DEPTH);

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_BGR_BIT  = 8;
  localparam int unsigned CTRL_BEB_BIT  = 9;
  localparam int unsigned CTRL_BEP_BIT  = 10;
  localparam int unsigned CTRL_PWR_BIT  = 11;

  typedef enum logic [3:0] {
    SEL_TIM, SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL, SEL_RAW, SEL_MIS,
    SEL_CLR, SEL_UPCUR, SEL_LPCUR, SEL_PAL, SEL_ID, SEL_NONE
  } sel_e;

  function automatic logic [7:0] id_byte(input int unsigned variant, input logic [2:0] k);
    case (k)
      3'd0:    return (variant == 2) ? 8'h11 : 8'h10;
      3'd1:    return 8'h11;
      3'd2:    return (variant == 2) ? 8'h24 : 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode import lcdc_pkg::*; #(
  parameter int unsigned VARIANT = 0
) (
  input  logic [IDX_W-1:0] idx_i,
  output sel_e             sel_o
);
  sel_e sel_mask_slot, sel_ctrl_slot;

  generate
    if (VARIANT == 0) begin : g_base
      assign sel_mask_slot = SEL_MASK;
      assign sel_ctrl_slot = SEL_CTRL;
    end else begin : g_swap
      assign sel_mask_slot = SEL_CTRL;
      assign sel_ctrl_slot = SEL_MASK;
    end
  endgenerate

  always_comb begin
    sel_o = SEL_NONE;
    if (idx_i[IDX_W-1:2] == '0) begin
      sel_o = SEL_TIM;
    end else if (idx_i[IDX_W-1:7] == 3'b001) begin
      sel_o = SEL_PAL;
    end else if (idx_i[IDX_W-1:3] == 7'h7F) begin
      sel_o = SEL_ID;
    end else begin
      case (idx_i)
        10'd4:   sel_o = SEL_UPB;
        10'd5:   sel_o = SEL_LPB;
        10'd6:   sel_o = sel_mask_slot;
        10'd7:   sel_o = sel_ctrl_slot;
        10'd8:   sel_o = SEL_RAW;
        10'd9:   sel_o = SEL_MIS;
        10'd10:  sel_o = SEL_CLR;
        10'd11:  sel_o = SEL_UPCUR;
        10'd12:  sel_o = SEL_LPCUR;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
  parameter int unsigned COL_W = 11,
  parameter int unsigned ROW_W = 11
) (
  input  logic [5:0]       t0_field_i,
  input  logic [9:0]       t1_field_i,
  output logic [COL_W-1:0] cols_o,
  output logic [ROW_W-1:0] rows_o
);
  // (t0[7:2]*4 + 4) * 4 == (t0[7:2] + 1) * 16
  assign cols_o = COL_W'({t0_field_i, 4'b0000}) + COL_W'(16);
  assign rows_o = ROW_W'(t1_field_i) + ROW_W'(1);
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic               mask_we_i,
  input  logic               clr_we_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  output logic [NUM_IRQ-1:0] raw_o,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [NUM_IRQ-1:0] masked_o,
  output logic               irq_o
);
  logic [NUM_IRQ-1:0] raw_q, mask_q, clr_bits;

  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_bits) | evt_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;

  // R7
  irq_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));

  // R6
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R6
  clr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && evt_i == '0) |=> ((raw_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/lcdc_palette.sv
module lcdc_palette import lcdc_pkg::*; #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PAL_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [PAL_AW-1:0] disp_addr_i,
  output logic [DATA_W-1:0] disp_rdata_o
);
  logic [DATA_W-1:0] mem_q [PAL_DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[bus_addr_i] <= wdata_i;
  end

  assign bus_rdata_o  = mem_q[bus_addr_i];
  assign disp_rdata_o = mem_q[disp_addr_i];
endmodule

// File: rtl/lcdc_regif.sv
module lcdc_regif import lcdc_pkg::*; #(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_IRQ = 4,
  parameter int unsigned CTRL_W  = 16,
  parameter int unsigned COL_W   = 11,
  parameter int unsigned ROW_W   = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [11:0]        addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic [PAL_AW-1:0]  pal_raddr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o,
  output logic               irq_o,
  output logic [COL_W-1:0]   cols_o,
  output logic [ROW_W-1:0]   rows_o,
  output logic [2:0]         bpp_o,
  output logic               en_o,
  output logic               bgr_o,
  output logic               be_byte_o,
  output logic               be_pix_o,
  output logic [DATA_W-1:0]  pal_rdata_o
);
  localparam int unsigned NUM_TIM = 4;

  logic [IDX_W-1:0]   idx;
  logic [1:0]         addr_unused;
  sel_e               sel;
  logic               wr, rd;
  logic [DATA_W-1:0]  tim_q [NUM_TIM];
  logic [DATA_W-1:0]  upb_q, lpb_q, rd_val, pal_bus_rdata;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_IRQ-1:0] raw_w, mask_w, masked_w;

  assign idx         = addr_i[11:2];
  assign addr_unused = addr_i[1:0];
  assign wr          = req_i & we_i;
  assign rd          = req_i & ~we_i;

  lcdc_decode #(.VARIANT(VARIANT)) u_decode (
    .idx_i (idx),
    .sel_o (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_TIM; i++) tim_q[i] <= '0;
      upb_q  <= '0;
      lpb_q  <= '0;
      ctrl_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_TIM:  tim_q[idx[1:0]] <= wdata_i;
        SEL_UPB:  upb_q  <= wdata_i;
        SEL_LPB:  lpb_q  <= wdata_i;
        SEL_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  lcdc_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .mask_we_i (wr && sel == SEL_MASK),
    .clr_we_i  (wr && sel == SEL_CLR),
    .wdata_i   (wdata_i[NUM_IRQ-1:0]),
    .raw_o     (raw_w),
    .mask_o    (mask_w),
    .masked_o  (masked_w),
    .irq_o     (irq_o)
  );

  lcdc_palette #(.DATA_W(DATA_W)) u_pal (
    .clk_i        (clk_i),
    .we_i         (wr && sel == SEL_PAL),
    .bus_addr_i   (idx[PAL_AW-1:0]),
    .wdata_i      (wdata_i),
    .bus_rdata_o  (pal_bus_rdata),
    .disp_addr_i  (pal_raddr_i),
    .disp_rdata_o (pal_rdata_o)
  );

  lcdc_geom #(.COL_W(COL_W), .ROW_W(ROW_W)) u_geom (
    .t0_field_i (tim_q[0][7:2]),
    .t1_field_i (tim_q[1][9:0]),
    .cols_o     (cols_o),
    .rows_o     (rows_o)
  );

  always_comb begin
    case (sel)
      SEL_TIM:             rd_val = tim_q[idx[1:0]];
      SEL_UPB, SEL_UPCUR:  rd_val = upb_q;
      SEL_LPB, SEL_LPCUR:  rd_val = lpb_q;
      SEL_MASK:            rd_val = DATA_W'(mask_w);
      SEL_CTRL:            rd_val = DATA_W'(ctrl_q);
      SEL_RAW:             rd_val = DATA_W'(raw_w);
      SEL_MIS:             rd_val = DATA_W'(masked_w);
      SEL_PAL:             rd_val = pal_bus_rdata;
      SEL_ID:              rd_val = DATA_W'(id_byte(VARIANT, idx[2:0]));
      default:             rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd) rdata_o <= rd_val;
      err_o <= req_i && (sel == SEL_NONE);
    end
  end

  assign bpp_o     = ctrl_q[3:1];
  assign en_o      = ctrl_q[CTRL_EN_BIT] & ctrl_q[CTRL_PWR_BIT];
  assign bgr_o     = ctrl_q[CTRL_BGR_BIT];
  assign be_byte_o = ctrl_q[CTRL_BEB_BIT];
  assign be_pix_o  = ctrl_q[CTRL_BEP_BIT];

  // R10
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_NONE) |=> (err_o && rdata_o == '0));

  // R4
  en_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> $past(wr));

  // R2
  geom_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cols_o[3:0] == 4'd0) && (cols_o != '0) && (rows_o != '0));

  // R13
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/lcdc_regif_test.sv
`timescale 1ns/1ps
module lcdc_regif_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  evt = '0;
  logic [6:0]  pal_ra = '0;

  logic [31:0] rd [3];
  logic [31:0] prd [3];
  logic        err [3];
  logic        irq [3];
  logic [10:0] cols [3];
  logic [10:0] rows [3];
  logic [2:0]  bpp [3];
  logic        en [3], bgr [3], beb [3], bep [3];

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lcdc_regif #(.VARIANT(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .evt_i(evt), .pal_raddr_i(pal_ra), .rdata_o(rd[0]), .err_o(err[0]), .irq_o(irq[0]),
    .cols_o(cols[0]), .rows_o(rows[0]), .bpp_o(bpp[0]), .en_o(en[0]), .bgr_o(bgr[0]),
    .be_byte_o(beb[0]), .be_pix_o(bep[0]), .pal_rdata_o(prd[0]));
  lcdc_regif #(.VARIANT(1)) uut_brd (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .evt_i(evt), .pal_raddr_i(pal_ra), .rdata_o(rd[1]), .err_o(err[1]), .irq_o(irq[1]),
    .cols_o(cols[1]), .rows_o(rows[1]), .bpp_o(bpp[1]), .en_o(en[1]), .bgr_o(bgr[1]),
    .be_byte_o(beb[1]), .be_pix_o(bep[1]), .pal_rdata_o(prd[1]));
  lcdc_regif #(.VARIANT(2)) uut_alt (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .evt_i(evt), .pal_raddr_i(pal_ra), .rdata_o(rd[2]), .err_o(err[2]), .irq_o(irq[2]),
    .cols_o(cols[2]), .rows_o(rows[2]), .bpp_o(bpp[2]), .en_o(en[2]), .bgr_o(bgr[2]),
    .be_byte_o(beb[2]), .be_pix_o(bep[2]), .pal_rdata_o(prd[2]));

  // reference model
  logic [31:0] m_tim [4];
  logic [31:0] m_upb, m_lpb;
  logic [15:0] m_ctrl [3];
  logic [3:0]  m_mask [3];
  logic [3:0]  m_raw;
  logic [31:0] m_pal [128];

  function automatic logic [7:0] m_id(int v, int k);
    case (k)
      0: return (v == 2) ? 8'h11 : 8'h10;
      1: return 8'h11;
      2: return (v == 2) ? 8'h24 : 8'h04;
      3: return 8'h00;
      4: return 8'h0D;
      5: return 8'hF0;
      6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic bit m_unmapped(int idx);
    return !(idx <= 12 || (idx >= 128 && idx < 256) || idx >= 1016);
  endfunction

  function automatic logic [31:0] m_read(int v, int idx);
    if (idx <= 3) return m_tim[idx];
    if (idx == 4 || idx == 11) return m_upb;
    if (idx == 5 || idx == 12) return m_lpb;
    if (idx == 6) return (v == 0) ? {28'd0, m_mask[v]} : {16'd0, m_ctrl[v]};
    if (idx == 7) return (v == 0) ? {16'd0, m_ctrl[v]} : {28'd0, m_mask[v]};
    if (idx == 8) return {28'd0, m_raw};
    if (idx == 9) return {28'd0, m_raw & m_mask[v]};
    if (idx >= 128 && idx < 256) return m_pal[idx-128];
    if (idx >= 1016) return {24'd0, m_id(v, idx-1016)};
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_outs();
    for (int v = 0; v < 3; v++) begin
      chk("R2 cols", 32'(cols[v]), ((m_tim[0] & 32'hFC) + 32'd4) * 32'd4);
      chk("R3 rows", 32'(rows[v]), (m_tim[1] & 32'h3FF) + 32'd1);
      chk("R4 bpp", 32'(bpp[v]), 32'(m_ctrl[v][3:1]));
      chk("R4 en", 32'(en[v]), 32'(m_ctrl[v][0] & m_ctrl[v][11]));
      chk("R4 bgr", 32'(bgr[v]), 32'(m_ctrl[v][8]));
      chk("R4 beb", 32'(beb[v]), 32'(m_ctrl[v][9]));
      chk("R4 bep", 32'(bep[v]), 32'(m_ctrl[v][10]));
      chk("R7 irq", 32'(irq[v]), 32'(|(m_raw & m_mask[v])));
    end
  endtask

  task automatic access(bit w, int idx, logic [31:0] d, logic [3:0] e, bit outs);
    @(negedge clk);
    req = 1'b1; we = w; addr = 12'(idx << 2); wdata = d; evt = e;
    @(posedge clk);
    m_raw = (m_raw & ~((w && idx == 10) ? d[3:0] : 4'h0)) | e;
    if (w) begin
      if (idx <= 3) m_tim[idx] = d;
      else if (idx == 4) m_upb = d;
      else if (idx == 5) m_lpb = d;
      else if (idx == 6 || idx == 7) begin
        for (int v = 0; v < 3; v++) begin
          if ((idx == 7) == (v == 0)) m_ctrl[v] = d[15:0];
          else m_mask[v] = d[3:0];
        end
      end else if (idx >= 128 && idx < 256) m_pal[idx-128] = d;
    end
    #2;
    for (int v = 0; v < 3; v++) begin
      if (!w) chk(m_unmapped(idx) ? "R10 rd" : "R1 R5 R8 R9 R13 rd", rd[v], m_read(v, idx));
      chk(w ? "R10 R12 err wr" : "R10 err rd", 32'(err[v]), 32'(m_unmapped(idx)));
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0;
    @(posedge clk);
    #2;
    for (int v = 0; v < 3; v++) chk("R10 err pulse", 32'(err[v]), 32'd0);
    if (outs) chk_outs();
  endtask

  task automatic sweep_reads();
    for (int i = 0; i < 1024; i++) access(1'b0, i, 32'd0, 4'h0, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_tim[i] = '0;
    m_upb = '0; m_lpb = '0; m_raw = '0;
    for (int v = 0; v < 3; v++) begin m_ctrl[v] = '0; m_mask[v] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    // R11 reset state
    for (int v = 0; v < 3; v++) begin
      chk("R11 rdata", rd[v], 32'd0);
      chk("R11 err", 32'(err[v]), 32'd0);
      chk("R11 irq", 32'(irq[v]), 32'd0);
      chk("R11 cols", 32'(cols[v]), 32'd16);
      chk("R11 rows", 32'(rows[v]), 32'd1);
      chk("R11 en", 32'(en[v]), 32'd0);
    end
    access(1'b0, 8, 32'd0, 4'h0, 1'b0);
    access(1'b0, 6, 32'd0, 4'h0, 1'b0);

    // R9 palette fill
    for (int i = 0; i < 128; i++) access(1'b1, 128 + i, 32'hC0DE0000 ^ (i * 32'h01030507), 4'h0, 1'b0);
    // R1 R5 program
    access(1'b1, 0, 32'h1234_56A8, 4'h0, 1'b1);
    access(1'b1, 1, 32'hFEDC_B9A7, 4'h0, 1'b1);
    access(1'b1, 2, 32'h0BAD_F00D, 4'h0, 1'b0);
    access(1'b1, 3, 32'h7777_1111, 4'h0, 1'b0);
    access(1'b1, 4, 32'h8000_4000, 4'h0, 1'b0);
    access(1'b1, 5, 32'h8000_9000, 4'h0, 1'b0);
    access(1'b1, 6, 32'h0000_0905, 4'h0, 1'b1);
    access(1'b1, 7, 32'hFFFF_0A0B, 4'h0, 1'b1);
    access(1'b0, 4, 32'd0, 4'h5, 1'b1);
    sweep_reads();

    // R10 R12 writes to unmapped and read-only slots
    for (int i = 8; i < 1024; i++) begin
      if (i == 10 || (i >= 128 && i < 256)) continue;
      access(1'b1, i, 32'hFFFF_FFFF, 4'h0, 1'b0);
    end
    chk_outs();
    sweep_reads();

    // R2 width sweep
    for (int i = 0; i < 256; i++) access(1'b1, 0, 32'hA5A5A500 | 32'(i), 4'h0, 1'b1);
    // R3 height sweep
    for (int i = 0; i < 1024; i++) access(1'b1, 1, 32'hFFFFFC00 | 32'(i), 4'h0, 1'b1);

    // R4 R5 control bit combinations in both slots
    for (int k = 0; k < 256; k++) begin
      logic [31:0] c;
      c = {16'hFFFF, 4'h0, 4'(k >> 4), 4'h0, 4'(k)};
      access(1'b1, 7, c, 4'h0, 1'b1);
      access(1'b1, 6, c, 4'h0, 1'b1);
    end

    // R6 R7 event/clear grid under each mask
    for (int m = 0; m < 16; m++) begin
      access(1'b1, 6, 32'(m), 4'h0, 1'b1);
      access(1'b1, 7, 32'(m), 4'h0, 1'b1);
      for (int e = 0; e < 16; e++) begin
        access(1'b1, 10, 32'(e ^ m), 4'(e), 1'b1);
        access(1'b0, 9, 32'd0, 4'h0, 1'b0);
      end
      access(1'b0, 8, 32'd0, 4'h0, 1'b1);
    end

    // R9 pixel-side port
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); pal_ra = 7'(i); #1;
      for (int v = 0; v < 3; v++) chk("R9 disp", prd[v], m_pal[i]);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule